// File: doc/BRIEF.md
# Received Byte Classifier and Router

This block sits behind the receive side of a two-channel serial input controller (a keyboard channel and an auxiliary pointing channel, where the auxiliary channel may fan out to four devices through a multiplexer). Each time the controller presents a status byte and a data byte, the block works out which logical port the byte belongs to. It attaches parity and timeout error flags, and it emits the result as a registered record with a one-cycle valid strobe.

The status byte drives all routing. In multiplexed mode the two upper status bits select one of four auxiliary sub-ports, and the multiplexer's error codes are rewritten into a canonical error byte. A byte that carries an error tag but holds ordinary data is credited to the last sub-port that sent a clean byte, provided that byte arrived recently. A loadable counter lets the host hide a set number of keyboard acknowledge bytes. A byte aimed at a port that is marked absent is dropped.

Top module: `rx_byte_router`

## Requirements
- R1: An event whose status bit 0 (output buffer full) is 0 produces no output strobe and changes no internal state.
- R2: With `mux_mode` set and status bit 5 (aux data) set, the port number is 2 plus status bits 7:6, which selects ports 2 to 5.
- R3: On the multiplexed path with status bit 2 (mux error) set, data 0xFC, 0xFD or 0xFE is delivered as 0xFE with the timeout flag set. Data 0xFF is delivered as 0xFE with the parity flag set. In both cases the port comes from status bits 7:6.
- R4: On the multiplexed path with the mux error bit set and any other data, the byte goes unchanged with no flags to the last recorded sub-port, but only while the window is open. When the window is closed, or no sub-port has been recorded since reset, the byte is delivered as 0xFE with the timeout flag, to the port given by status bits 7:6.
- R5: Off the multiplexed path (`mux_mode` clear, or status bit 5 clear), the port is 1 when status bit 5 is set and 0 otherwise. The parity flag copies status bit 7 and the timeout flag copies status bit 6.
- R6: While the suppression counter is nonzero, a port-0 byte of 0xFA or 0xFE is dropped and the counter decrements by one. A pulse on `sup_load` loads `sup_value` into the counter. Bytes for other ports, and other values, pass through.
- R7: A byte whose resolved port has a clear bit in `port_present` is not delivered.
- R8: Each multiplexed-path byte whose mux error bit is clear records its port and restarts the window count at zero. Each `ms_tick` advances the count, and the window stays open while fewer than WINDOW_MS ticks (default 100) have arrived.
- R9: A delivered byte shows up on the outputs on the clock edge after its event, with `out_valid` high for exactly one cycle. `out_flags` bit 0 is parity and bit 1 is timeout.
- R10: When `sup_load` and a suppressible keyboard byte arrive in the same cycle, the byte is judged against the old count and dropped, and the loaded value wins over the decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | A status/data pair is presented this cycle |
| evt_status | input | 8 | Controller status byte |
| evt_data | input | 8 | Received data byte |
| mux_mode | input | 1 | Multiplexed auxiliary mode is active |
| port_present | input | 6 | One bit per logical port 0..5; a clear bit discards that port's bytes |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| sup_load | input | 1 | Load the acknowledge-suppression counter |
| sup_value | input | SUP_W | Value loaded into the suppression counter |
| out_valid | output | 1 | One-cycle strobe for a delivered byte |
| out_port | output | 3 | Logical port of the delivered byte |
| out_data | output | 8 | Delivered data byte |
| out_flags | output | 2 | Bit 0 parity error, bit 1 timeout |

## Verification
Two things can land in one cycle: a counter reload and a keyboard acknowledge that the old count would consume. The bench sets the counter to one, then sends an 0xFA keyboard byte together with a reload of two. Correct behaviour is a dropped byte followed by exactly two more drops, so the fourth acknowledge appears on the outputs. The same kind of collision can occur between a window restart and a millisecond tick. The bench covers it by sending clean sub-port bytes between tick bursts and checking which port an error-tagged byte is credited to.

// File: rtl/rx_byte_router.sv
module rx_byte_router #(
  parameter int WINDOW_MS = 100,
  parameter int SUP_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic [7:0]       evt_status,
  input  logic [7:0]       evt_data,
  input  logic             mux_mode,
  input  logic [5:0]       port_present,
  input  logic             ms_tick,
  input  logic             sup_load,
  input  logic [SUP_W-1:0] sup_value,
  output logic             out_valid,
  output logic [2:0]       out_port,
  output logic [7:0]       out_data,
  output logic [1:0]       out_flags
);
  localparam int WIN_W = $clog2(WINDOW_MS + 1);
  localparam logic [WIN_W-1:0] WIN_LIM = WIN_W'(WINDOW_MS);
  localparam logic [2:0] P_KBD = 3'd0;
  localparam logic [2:0] P_AUX = 3'd1;
  localparam logic [2:0] P_MUX0 = 3'd2;
  localparam logic [7:0] ERR_BYTE = 8'hFE;

  logic             armed;
  logic [WIN_W-1:0] win_cnt;
  logic [2:0]       last_port;
  logic [SUP_W-1:0] sup_cnt;

  logic       full, aux_tag, mux_err, mux_path, win_open;
  logic [2:0] c_port;
  logic [7:0] c_data;
  logic [1:0] c_flags;
  logic       is_ack, drop_ack, deliver, record;

  assign full     = evt_valid & evt_status[0];
  assign aux_tag  = evt_status[5];
  assign mux_err  = evt_status[2];
  assign mux_path = mux_mode & aux_tag;
  assign win_open = armed & (win_cnt < WIN_LIM);

  always_comb begin
    c_data  = evt_data;
    c_flags = 2'b00;
    c_port  = aux_tag ? P_AUX : P_KBD;
    if (mux_path) begin
      c_port = P_MUX0 + {1'b0, evt_status[7:6]};
      if (mux_err) begin
        case (evt_data)
          8'hFC, 8'hFD, 8'hFE: begin
            c_flags = 2'b10;
            c_data  = ERR_BYTE;
          end
          8'hFF: begin
            c_flags = 2'b01;
            c_data  = ERR_BYTE;
          end
          default: begin
            if (win_open) begin
              c_port = last_port;
            end else begin
              c_flags = 2'b10;
              c_data  = ERR_BYTE;
            end
          end
        endcase
      end
    end else begin
      c_flags = {evt_status[6], evt_status[7]};
    end
  end

  assign is_ack   = (c_data == 8'hFA) | (c_data == 8'hFE);
  assign drop_ack = full & (sup_cnt != '0) & (c_port == P_KBD) & is_ack;
  assign deliver  = full & ~drop_ack & port_present[c_port];
  assign record   = full & mux_path & ~mux_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_port  <= '0;
      out_data  <= '0;
      out_flags <= '0;
    end else begin
      out_valid <= deliver;
      if (deliver) begin
        out_port  <= c_port;
        out_data  <= c_data;
        out_flags <= c_flags;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      win_cnt   <= '0;
      last_port <= P_MUX0;
    end else if (record) begin
      armed     <= 1'b1;
      win_cnt   <= '0;
      last_port <= c_port;
    end else if (ms_tick && armed && win_cnt < WIN_LIM) begin
      win_cnt <= win_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         sup_cnt <= '0;
    else if (sup_load)  sup_cnt <= sup_value;
    else if (drop_ack)  sup_cnt <= sup_cnt - 1'b1;
  end
endmodule

module rx_byte_router_chk #(
  parameter int SUP_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_valid,
  input logic [7:0]       evt_status,
  input logic [7:0]       evt_data,
  input logic             mux_mode,
  input logic [5:0]       port_present,
  input logic             sup_load,
  input logic [SUP_W-1:0] sup_value,
  input logic             out_valid,
  input logic [2:0]       out_port,
  input logic [7:0]       out_data,
  input logic [1:0]       out_flags
);
  logic [5:0] prev_present;
  always_ff @(posedge clk) prev_present <= port_present;

  AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_status[0] |=> !out_valid); // R1

  AST_PORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_port <= 3'd5); // R2

  AST_MUX_ERR_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_status[0] && mux_mode && evt_status[5] && evt_status[2]
      && evt_data >= 8'hFC && port_present[3'd2 + {1'b0, evt_status[7:6]}]
    |=> out_valid && out_data == 8'hFE && out_flags != 2'b00); // R3

  AST_LEGACY_AUX: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_status[0] && !mux_mode && evt_status[5] && port_present[1]
    |=> out_valid && out_port == 3'd1
        && out_flags == {$past(evt_status[6]), $past(evt_status[7])}); // R5

  AST_ABSENT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> prev_present[out_port]); // R7

  AST_STROBE_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(evt_valid)); // R9
endmodule

bind rx_byte_router rx_byte_router_chk #(.SUP_W(SUP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_status(evt_status),
  .evt_data(evt_data), .mux_mode(mux_mode), .port_present(port_present),
  .sup_load(sup_load), .sup_value(sup_value), .out_valid(out_valid),
  .out_port(out_port), .out_data(out_data), .out_flags(out_flags)
);

// File: tb/rx_byte_router_test.sv
`timescale 1ns/1ps
module rx_byte_router_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_valid = 1'b0;
  logic [7:0] evt_status = '0;
  logic [7:0] evt_data = '0;
  logic       mux_mode = 1'b0;
  logic [5:0] port_present = 6'h3F;
  logic       ms_tick = 1'b0;
  logic       sup_load = 1'b0;
  logic [3:0] sup_value = '0;
  logic       out_valid;
  logic [2:0] out_port;
  logic [7:0] out_data;
  logic [1:0] out_flags;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_byte_router uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_status(evt_status),
    .evt_data(evt_data), .mux_mode(mux_mode), .port_present(port_present),
    .ms_tick(ms_tick), .sup_load(sup_load), .sup_value(sup_value),
    .out_valid(out_valid), .out_port(out_port), .out_data(out_data),
    .out_flags(out_flags)
  );

  // {mux, present, status, data, exp_valid, exp_port, exp_flags, exp_data}
  localparam int NV = 13;
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 6'h3F, 8'h01, 8'h1C, 1'b1, 3'd0, 2'b00, 8'h1C}, // R5 kbd clean
    {1'b0, 6'h3F, 8'hA1, 8'h55, 1'b1, 3'd1, 2'b01, 8'h55}, // R5 aux parity
    {1'b0, 6'h3F, 8'h41, 8'h33, 1'b1, 3'd0, 2'b10, 8'h33}, // R5 kbd timeout
    {1'b0, 6'h3F, 8'h20, 8'h44, 1'b0, 3'd0, 2'b00, 8'h00}, // R1 empty
    {1'b1, 6'h3F, 8'h61, 8'h77, 1'b1, 3'd3, 2'b00, 8'h77}, // R2 sub-port 3
    {1'b1, 6'h3F, 8'hE1, 8'h88, 1'b1, 3'd5, 2'b00, 8'h88}, // R2 sub-port 5
    {1'b1, 6'h3F, 8'hC1, 8'h21, 1'b1, 3'd0, 2'b11, 8'h21}, // R5 kbd in mux mode
    {1'b1, 6'h3F, 8'h25, 8'hFC, 1'b1, 3'd2, 2'b10, 8'hFE}, // R3 FC timeout
    {1'b1, 6'h3F, 8'hA5, 8'hFF, 1'b1, 3'd4, 2'b01, 8'hFE}, // R3 FF parity
    {1'b1, 6'h3F, 8'h65, 8'hFD, 1'b1, 3'd3, 2'b10, 8'hFE}, // R3 FD timeout
    {1'b0, 6'h3D, 8'h21, 8'h10, 1'b0, 3'd0, 2'b00, 8'h00}, // R7 aux absent
    {1'b1, 6'h1F, 8'hE1, 8'h11, 1'b0, 3'd0, 2'b00, 8'h00}, // R7 sub-port 5 absent
    {1'b0, 6'h3F, 8'hE1, 8'h09, 1'b1, 3'd1, 2'b11, 8'h09}  // R5 mux off, aux
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic expect_out(input string tag, input logic v, input logic [2:0] p,
                            input logic [1:0] f, input logic [7:0] d);
    chk(tag, {31'd0, out_valid}, {31'd0, v});
    if (v) chk(tag, {21'd0, out_port, out_flags, out_data}, {21'd0, p, f, d});
  endtask

  task automatic send(input logic m, input logic [5:0] pres, input logic [7:0] st,
                      input logic [7:0] d, input logic ld, input logic [3:0] lv);
    @(negedge clk);
    mux_mode = m; port_present = pres; evt_status = st; evt_data = d;
    evt_valid = 1'b1; sup_load = ld; sup_value = lv;
    @(negedge clk);
    evt_valid = 1'b0; sup_load = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ms_tick = 1'b1;
      @(negedge clk); ms_tick = 1'b0;
    end
  endtask

  task automatic load_sup(input logic [3:0] v);
    @(negedge clk); sup_load = 1'b1; sup_value = v;
    @(negedge clk); sup_load = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog got=timeout exp=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R9 reset state", 1'b0, 3'd0, 2'b00, 8'h00);
    chk("R9 reset regs", {21'd0, out_port, out_flags, out_data}, 32'd0);
    rst_n = 1'b1;

    // R4: no sub-port recorded yet, error-tagged ordinary byte is a timeout
    send(1'b1, 6'h3F, 8'h25, 8'h12, 1'b0, 4'd0);
    expect_out("R4 unarmed timeout", 1'b1, 3'd2, 2'b10, 8'hFE);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][36], VEC[i][35:30], VEC[i][29:22], VEC[i][21:14], 1'b0, 4'd0);
      expect_out($sformatf("table[%0d]", i), VEC[i][13], VEC[i][12:10], VEC[i][9:8], VEC[i][7:0]);
    end

    // R9: strobe lasts one cycle
    send(1'b0, 6'h3F, 8'h01, 8'h2A, 1'b0, 4'd0);
    expect_out("R9 delivered", 1'b1, 3'd0, 2'b00, 8'h2A);
    @(negedge clk);
    chk("R9 strobe one cycle", {31'd0, out_valid}, 32'd0);

    // R4 R8: window edge at WINDOW_MS ticks
    send(1'b1, 6'h3F, 8'h61, 8'h01, 1'b0, 4'd0);
    ticks(99);
    send(1'b1, 6'h3F, 8'h25, 8'h12, 1'b0, 4'd0);
    expect_out("R4 recovered inside window", 1'b1, 3'd3, 2'b00, 8'h12);
    ticks(1);
    send(1'b1, 6'h3F, 8'h25, 8'h12, 1'b0, 4'd0);
    expect_out("R8 window closed", 1'b1, 3'd2, 2'b10, 8'hFE);

    // R8: a later clean byte restarts the window and moves the recorded port
    send(1'b1, 6'h3F, 8'hA1, 8'h02, 1'b0, 4'd0);
    ticks(60);
    send(1'b1, 6'h3F, 8'hE1, 8'h03, 1'b0, 4'd0);
    ticks(60);
    send(1'b1, 6'h3F, 8'h25, 8'h34, 1'b0, 4'd0);
    expect_out("R8 restart", 1'b1, 3'd5, 2'b00, 8'h34);

    // R1: an empty event does not disturb the window
    send(1'b1, 6'h3F, 8'h60, 8'h00, 1'b0, 4'd0);
    chk("R1 empty event", {31'd0, out_valid}, 32'd0);
    send(1'b1, 6'h3F, 8'h25, 8'h35, 1'b0, 4'd0);
    expect_out("R1 window kept", 1'b1, 3'd5, 2'b00, 8'h35);

    // R6: suppression of keyboard acknowledges
    load_sup(4'd2);
    send(1'b0, 6'h3F, 8'h01, 8'hFA, 1'b0, 4'd0);
    chk("R6 kbd FA dropped", {31'd0, out_valid}, 32'd0);
    send(1'b0, 6'h3F, 8'h21, 8'hFA, 1'b0, 4'd0);
    expect_out("R6 aux FA passes", 1'b1, 3'd1, 2'b00, 8'hFA);
    send(1'b0, 6'h3F, 8'h01, 8'h1C, 1'b0, 4'd0);
    expect_out("R6 kbd other passes", 1'b1, 3'd0, 2'b00, 8'h1C);
    send(1'b0, 6'h3F, 8'h01, 8'hFE, 1'b0, 4'd0);
    chk("R6 kbd FE dropped", {31'd0, out_valid}, 32'd0);
    send(1'b0, 6'h3F, 8'h01, 8'hFA, 1'b0, 4'd0);
    expect_out("R6 counter exhausted", 1'b1, 3'd0, 2'b00, 8'hFA);

    // R10: reload coinciding with a consumed acknowledge
    load_sup(4'd1);
    send(1'b0, 6'h3F, 8'h01, 8'hFA, 1'b1, 4'd2);
    chk("R10 coincident drop", {31'd0, out_valid}, 32'd0);
    send(1'b0, 6'h3F, 8'h01, 8'hFA, 1'b0, 4'd0);
    chk("R10 second drop", {31'd0, out_valid}, 32'd0);
    send(1'b0, 6'h3F, 8'h01, 8'hFE, 1'b0, 4'd0);
    chk("R10 third drop", {31'd0, out_valid}, 32'd0);
    send(1'b0, 6'h3F, 8'h01, 8'hFA, 1'b0, 4'd0);
    expect_out("R10 after reload used", 1'b1, 3'd0, 2'b00, 8'hFA);

    done = 1'b1;
    finish_run();
  end
endmodule